// File: doc/BRIEF.md
# Synchronous Multiplexed Parallel Bus Slave

This block is the peripheral end of a synchronous external bus. A host processor drives one 16-bit wire group that carries first an address and then data. The slave takes the word address from that wire group in the cycle where chip select and the address strobe are both low. It then serves a burst of beats from a local word memory, reached through a simple port that the slave addresses. The bus clock runs freely. Chip select brackets each burst, and it stays high for an idle gap of any length between frames.

On reads, the first data word reaches the bus after a programmable number of clock edges. This lets the slave match the read latency set in the host's bus controller. If the two latencies differ, the host samples the wrong beats. On writes, the slave takes one word on every clock edge where write enable is low, starting with the edge after the address. Each burst is 4, 8, 16 or 32 beats long. It either counts upward linearly or wraps inside a window of burst length, aligned to that length. The shared wire group is split at the block edge into an input, an output and an output-enable, and the pad buffer sits outside the block.

Top module: `smx_slave`

## Requirements
- R1: While reset is held, and after it ends with chip select high, `adDriveEn` and `memWe` are both 0.
- R2: The burst start address is `adIn[ADDR_W-1:0]` sampled on the first rising edge with `csN` and `advN` both low in a frame. Bus cycles with `csN` low and `advN` high before that edge do not start a burst.
- R3: With a wait count W of `cfgWait` (the value 0 is treated as 1), read beat k holds `adOut` from the (W+k)-th rising edge after the address edge until the next edge. Read beats follow on consecutive edges.
- R4: `adDriveEn` is 1 only inside the read-beat window of R3 while `csN` and `oeN` are both low. Otherwise the bus is released.
- R5: `cfgLenCode` 2'b00, 2'b01, 2'b10 and 2'b11 set 4, 8, 16 and 32 beats. Beats beyond that number are neither driven nor written.
- R6: With `cfgWrap`=0, beat k uses word address (start + k) modulo 2^ADDR_W.
- R7: With `cfgWrap`=1, beat k uses the address whose bits above the window size equal those of start, and whose low bits are (start + k) modulo the burst length.
- R8: Each rising edge after the address edge with `weN` low, within the burst length, writes `adIn` to the current beat address through `memWe`/`memAddr`/`memWdata`.
- R9: A rising edge with `csN` high ends the frame at once. No later writes or drive occur, the bus is released as soon as `csN` rises, and the next frame starts cleanly from R2.
- R10: `cfgWait`, `cfgLenCode` and `cfgWrap` are taken only on edges where `csN` is high. Changes made while `csN` is low do not affect the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Free-running bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select, frames one burst |
| advN | input | 1 | Active-low address strobe |
| oeN | input | 1 | Active-low output enable from the host |
| weN | input | 1 | Active-low write enable from the host |
| adIn | input | 16 | Shared address/data wires as seen at the pad input |
| adOut | output | 16 | Read data toward the pad output |
| adDriveEn | output | 1 | Pad output enable for the shared wires |
| cfgWait | input | 4 | Read wait-state count |
| cfgLenCode | input | 2 | Burst length code |
| cfgWrap | input | 1 | 1 = wrapping burst, 0 = linear |
| memAddr | output | ADDR_W | Local memory word address |
| memWe | output | 1 | Local memory write strobe |
| memWdata | output | 16 | Local memory write data |
| memRdata | input | 16 | Local memory read data, combinational from memAddr |

## Verification
Two events can land on the same clock edge. One is the end of a frame when chip select rises. The other is a pending beat, either a write with write enable still low and new data on the wires, or a read with output enable still low. The bench causes this by raising chip select in the middle of a write burst while holding write enable low with fresh data. It also raises chip select during a read beat window and checks the output enable a moment later. A second collision, configuration changing while a frame is running, is caused by scrambling all three configuration inputs right after the address edge. The bench judges both collisions at the ports. It compares the whole local memory against a bench-computed image, and it compares drive timing and data per beat against the latency and the address order computed from the requirements.

// File: rtl/smx_pkg.sv
package smx_pkg;

  typedef enum logic {
    S_IDLE,
    S_ACCESS
  } smx_state_e;

  // strobes and registered configuration passed from control to datapath
  typedef struct packed {
    logic       loadAddr;
    logic       advance;
    logic       loadRead;
    logic       clearFrame;
    logic       wrapEn;
    logic [1:0] lenCode;
  } smx_ctrl_t;

endpackage

// File: rtl/smx_ctrl.sv
module smx_ctrl
  import smx_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int CNT_W  = 6
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              advN,
  input  logic              weN,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic [1:0]        cfgLenCode,
  input  logic              cfgWrap,
  output smx_ctrl_t         ctrl,
  output logic              memWe
);

  smx_state_e        state;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitQ;
  logic [WAIT_W-1:0] effWait;
  logic [1:0]        lenQ;
  logic              wrapQ;
  logic [CNT_W-1:0]  beatCnt;
  logic [CNT_W-1:0]  lenBeats;
  logic              beatsLeft;
  logic              startHit;
  logic              inFrame;
  logic              writeHit;
  logic              readHit;

  // configuration is only taken between frames
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      waitQ <= WAIT_W'(1);
      lenQ  <= 2'b00;
      wrapQ <= 1'b0;
    end else if (csN) begin
      waitQ <= cfgWait;
      lenQ  <= cfgLenCode;
      wrapQ <= cfgWrap;
    end
  end

  always_comb begin
    effWait   = (waitQ == '0) ? WAIT_W'(1) : waitQ;
    lenBeats  = CNT_W'(4) << lenQ;
    beatsLeft = beatCnt < lenBeats;
    startHit  = (state == S_IDLE) && !csN && !advN;
    inFrame   = (state == S_ACCESS) && !csN;
    writeHit  = inFrame && !weN && beatsLeft;
    readHit   = inFrame && weN && beatsLeft && (waitCnt >= effWait);

    ctrl.loadAddr   = startHit;
    ctrl.advance    = writeHit || readHit;
    ctrl.loadRead   = readHit;
    ctrl.clearFrame = (state == S_ACCESS) && csN;
    ctrl.wrapEn     = wrapQ;
    ctrl.lenCode    = lenQ;
    memWe           = writeHit;
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      beatCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (startHit) begin
            state   <= S_ACCESS;
            waitCnt <= WAIT_W'(1);
            beatCnt <= '0;
          end
        end
        S_ACCESS: begin
          if (csN) begin
            state   <= S_IDLE;
            waitCnt <= '0;
            beatCnt <= '0;
          end else begin
            if (writeHit || readHit) begin
              beatCnt <= beatCnt + CNT_W'(1);
            end else if (waitCnt < effWait) begin
              waitCnt <= waitCnt + WAIT_W'(1);
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/smx_datapath.sv
module smx_datapath
  import smx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              busClk,
  input  logic              rstN,
  input  smx_ctrl_t         ctrl,
  input  logic              csN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] adOut,
  output logic              adDriveEn
);

  logic [ADDR_W-1:0] beatAddr;
  logic [ADDR_W-1:0] lenWords;
  logic [ADDR_W-1:0] winMask;
  logic [ADDR_W-1:0] nextLinear;
  logic [ADDR_W-1:0] nextWrap;
  logic [DATA_W-1:0] outReg;
  logic              validQ;

  always_comb begin
    lenWords   = ADDR_W'(4) << ctrl.lenCode;
    winMask    = lenWords - ADDR_W'(1);
    nextLinear = beatAddr + ADDR_W'(1);
    nextWrap   = (beatAddr & ~winMask) | (nextLinear & winMask);
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      beatAddr <= '0;
      outReg   <= '0;
      validQ   <= 1'b0;
    end else if (ctrl.clearFrame) begin
      validQ <= 1'b0;
    end else begin
      if (ctrl.loadAddr) begin
        beatAddr <= addrIn;
      end else if (ctrl.advance) begin
        beatAddr <= ctrl.wrapEn ? nextWrap : nextLinear;
      end
      validQ <= ctrl.loadRead;
      if (ctrl.loadRead) begin
        outReg <= memRdata;
      end
    end
  end

  assign memAddr   = beatAddr;
  assign adOut     = outReg;
  assign adDriveEn = validQ && !csN && !oeN;

endmodule

// File: rtl/smx_slave.sv
module smx_slave
  import smx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              advN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adDriveEn,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic [1:0]        cfgLenCode,
  input  logic              cfgWrap,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int MAX_BEATS = 32;
  localparam int CNT_W     = $clog2(MAX_BEATS) + 1;

  smx_ctrl_t ctrl;

  smx_ctrl #(
    .WAIT_W(WAIT_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .busClk    (busClk),
    .rstN      (rstN),
    .csN       (csN),
    .advN      (advN),
    .weN       (weN),
    .cfgWait   (cfgWait),
    .cfgLenCode(cfgLenCode),
    .cfgWrap   (cfgWrap),
    .ctrl      (ctrl),
    .memWe     (memWe)
  );

  smx_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_datapath (
    .busClk   (busClk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .csN      (csN),
    .oeN      (oeN),
    .addrIn   (adIn[ADDR_W-1:0]),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .adOut    (adOut),
    .adDriveEn(adDriveEn)
  );

  assign memWdata = adIn;

endmodule

// File: rtl/smx_slave_chk.sv
module smx_slave_chk #(
  parameter int ADDR_W = 8
) (
  input logic              busClk,
  input logic              rstN,
  input logic              csN,
  input logic              advN,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              adDriveEn
);

  logic       frameOn;
  logic [3:0] sinceAddr;
  logic [6:0] wrCount;

  // frame tracking rebuilt from the port pins only
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      frameOn   <= 1'b0;
      sinceAddr <= '0;
      wrCount   <= '0;
    end else if (csN) begin
      frameOn   <= 1'b0;
      sinceAddr <= '0;
      wrCount   <= '0;
    end else begin
      if (!frameOn && !advN) begin
        frameOn   <= 1'b1;
        sinceAddr <= '0;
      end else if (frameOn && sinceAddr != 4'hF) begin
        sinceAddr <= sinceAddr + 4'd1;
      end
      if (memWe && wrCount != 7'h7F) begin
        wrCount <= wrCount + 7'd1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge busClk) disable iff (!rstN)
    memWe |-> wrCount < 7'd32); // R5

  AST_NO_EARLY_DRIVE: assert property (@(posedge busClk) disable iff (!rstN)
    adDriveEn |-> frameOn && sinceAddr >= 4'd1); // R3

  AST_IDLE_QUIET: assert property (@(posedge busClk) disable iff (!rstN)
    (csN && $past(csN)) |-> (!memWe && !adDriveEn)); // R9

  AST_WRITE_MOVES: assert property (@(posedge busClk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> memAddr != $past(memAddr)); // R8

  AST_WRITE_IN_FRAME: assert property (@(posedge busClk) disable iff (!rstN)
    memWe |-> frameOn); // R2

endmodule

bind smx_slave smx_slave_chk #(
  .ADDR_W(ADDR_W)
) u_chk (
  .busClk   (busClk),
  .rstN     (rstN),
  .csN      (csN),
  .advN     (advN),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .adDriveEn(adDriveEn)
);

// File: tb/smx_slave_bench.sv
module smx_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        busClk = 1'b0;
  logic        rstN;
  logic        csN, advN, oeN, weN;
  logic [15:0] adIn;
  logic [15:0] adOut;
  logic        adDriveEn;
  logic [3:0]  cfgWait;
  logic [1:0]  cfgLenCode;
  logic        cfgWrap;
  logic [7:0]  memAddr;
  logic        memWe;
  logic [15:0] memWdata;
  logic [15:0] memRdata;

  logic [15:0] mem    [256];
  logic [15:0] refMem [256];

  int nChecks = 0;
  int nBad    = 0;
  int salt    = 0;

  always #(CLK_PERIOD / 2) busClk = ~busClk;

  smx_slave u_smx_slave (
    .busClk    (busClk),
    .rstN      (rstN),
    .csN       (csN),
    .advN      (advN),
    .oeN       (oeN),
    .weN       (weN),
    .adIn      (adIn),
    .adOut     (adOut),
    .adDriveEn (adDriveEn),
    .cfgWait   (cfgWait),
    .cfgLenCode(cfgLenCode),
    .cfgWrap   (cfgWrap),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memWdata  (memWdata),
    .memRdata  (memRdata)
  );

  assign memRdata = mem[memAddr];
  always @(posedge busClk) if (memWe) mem[memAddr] <= memWdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] beatAddrOf(input logic [7:0] start, input int k,
                                            input logic [1:0] code, input bit wrap);
    int len = 4 << code;
    int lin = int'(start) + k;
    if (wrap) return 8'((int'(start) & ~(len - 1)) | (lin & (len - 1)));
    return 8'(lin);
  endfunction

  task automatic setCfg(input logic [3:0] w, input logic [1:0] code, input bit wrap);
    @(negedge busClk);
    csN = 1'b1; cfgWait = w; cfgLenCode = code; cfgWrap = wrap;
    @(posedge busClk);
  endtask

  // read frame; preIdle cycles of csN low with advN high before the address;
  // cutAt >= 0 raises csN at that bus position; scramble perturbs cfg mid-frame
  task automatic readBurst(input logic [7:0] start, input logic [3:0] w, input logic [1:0] code,
                           input bit wrap, input bit oeOn, input int preIdle, input int cutAt,
                           input bit scramble, input string tag);
    int len  = 4 << code;
    int effW = (w == 0) ? 1 : int'(w);
    @(negedge busClk);
    for (int i = 0; i < preIdle; i++) begin
      csN = 1'b0; advN = 1'b1; adIn = 16'h00C3; oeN = 1'b1; weN = 1'b1;
      @(posedge busClk); @(negedge busClk);
    end
    csN = 1'b0; advN = 1'b0; adIn = {8'h00, start}; oeN = 1'b1; weN = 1'b1;
    @(posedge busClk); @(negedge busClk);
    advN = 1'b1; adIn = 16'hBEEF; oeN = !oeOn;
    if (scramble) begin
      cfgWait = ~w; cfgLenCode = ~code; cfgWrap = !wrap;
    end
    for (int p = 0; p <= effW + len; p++) begin
      bit expDrive = oeOn && (p >= effW) && (p < effW + len);
      if (p == cutAt) begin
        csN = 1'b1;
        #1;
        chk(adDriveEn == 1'b0, "R9 release on cs high", 32'(adDriveEn), 32'd0);
        break;
      end
      chk(adDriveEn == expDrive, {tag, " R4 drive window"}, 32'(adDriveEn), 32'(expDrive));
      if (expDrive) begin
        logic [7:0] a = beatAddrOf(start, p - effW, code, wrap);
        chk(adOut == mem[a], {tag, " R3 beat data"}, 32'(adOut), 32'(mem[a]));
      end
      @(posedge busClk); @(negedge busClk);
    end
    csN = 1'b1; oeN = 1'b1;
    if (scramble) begin
      cfgWait = w; cfgLenCode = code; cfgWrap = wrap;
    end
    @(posedge busClk);
  endtask

  // write frame of nBeats beats; cutEarly raises csN while a beat is still offered
  task automatic writeBurst(input logic [7:0] start, input logic [1:0] code, input bit wrap,
                            input int nBeats, input bit cutEarly, input string tag);
    int len = 4 << code;
    int bad = 0;
    @(negedge busClk);
    csN = 1'b0; advN = 1'b0; adIn = {8'h00, start}; weN = 1'b1; oeN = 1'b1;
    @(posedge busClk); @(negedge busClk);
    advN = 1'b1;
    for (int k = 0; k < nBeats; k++) begin
      logic [15:0] d = 16'((int'(start) * 37) + (k * 101) + (salt * 977) + 16'h1234);
      weN = 1'b0; adIn = d;
      if (k < len) refMem[beatAddrOf(start, k, code, wrap)] = d;
      @(posedge busClk); @(negedge busClk);
    end
    if (cutEarly) begin
      csN = 1'b1; weN = 1'b0; adIn = 16'hF00D;
      @(posedge busClk); @(negedge busClk);
    end
    weN = 1'b1; csN = 1'b1;
    @(posedge busClk); @(negedge busClk);
    salt++;
    for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) bad++;
    chk(bad == 0, tag, 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge busClk);
    nBad++;
    $display("FAIL watchdog actual=%0d expected=finish", WATCHDOG);
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 16'((i * 16'h0101) ^ 16'h5A00);
      refMem[i] = mem[i];
    end
    rstN = 1'b0; csN = 1'b1; advN = 1'b1; oeN = 1'b1; weN = 1'b1; adIn = '0;
    cfgWait = 4'd1; cfgLenCode = 2'b00; cfgWrap = 1'b0;
    repeat (3) @(posedge busClk);
    @(negedge busClk);
    chk(adDriveEn == 1'b0 && memWe == 1'b0, "R1 reset quiet", {adDriveEn, memWe}, 32'd0);
    rstN = 1'b1;
    @(posedge busClk); @(negedge busClk);
    chk(adDriveEn == 1'b0 && memWe == 1'b0, "R1 after reset", {adDriveEn, memWe}, 32'd0);

    // R3 R5 R6 R7 sweep: wait counts incl. 0, every length, both orders, two starts
    for (int w = 0; w <= 4; w++)
      for (int c = 0; c < 4; c++)
        for (int wr = 0; wr < 2; wr++)
          for (int s = 0; s < 2; s++) begin
            logic [7:0] st = (s == 0) ? 8'h1D : 8'hFE;
            setCfg(4'(w), 2'(c), wr[0]);
            readBurst(st, 4'(w), 2'(c), wr[0], 1'b1, 0, -1, 1'b0,
                      wr[0] ? "R7 wrap read" : "R6 linear read");
          end

    // R4: output enable held high, bus never driven
    setCfg(4'd2, 2'b01, 1'b0);
    readBurst(8'h40, 4'd2, 2'b01, 1'b0, 1'b0, 0, -1, 1'b0, "R4 oe high");

    // R2: idle cs-low cycles without address strobe before the address
    setCfg(4'd3, 2'b00, 1'b1);
    readBurst(8'h66, 4'd3, 2'b00, 1'b1, 1'b1, 3, -1, 1'b0, "R2 late strobe");

    // R10: config scrambled after address edge
    setCfg(4'd2, 2'b01, 1'b1);
    readBurst(8'h2B, 4'd2, 2'b01, 1'b1, 1'b1, 0, -1, 1'b1, "R10 cfg frozen");

    // R8 R5 R6 R7: writes offered two beats past the burst length
    for (int c = 0; c < 4; c++)
      for (int wr = 0; wr < 2; wr++) begin
        setCfg(4'd1, 2'(c), wr[0]);
        writeBurst(8'h37 + 8'(c * 64), 2'(c), wr[0], (4 << c) + 2, 1'b0,
                   wr[0] ? "R8 R7 wrap write" : "R8 R6 linear write");
      end

    // R9: write cut by cs while a beat is still offered
    setCfg(4'd1, 2'b11, 1'b0);
    writeBurst(8'h80, 2'b11, 1'b0, 5, 1'b1, "R9 write cut");

    // R9: read cut mid-window, then a clean frame rearms
    setCfg(4'd2, 2'b10, 1'b0);
    readBurst(8'h90, 4'd2, 2'b10, 1'b0, 1'b1, 0, 4, 1'b0, "R9 read cut");
    readBurst(8'h80, 4'd2, 2'b10, 1'b0, 1'b1, 0, -1, 1'b0, "R9 rearm read");

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule